// File: doc/BRIEF.md
# Digit-Serial Montgomery Multiplier

This block forms the Montgomery product of two operands, P ≡ A·B·r^(-N) mod M, with radix r = 2^DIG_W. It works one digit of A per clock. In each iteration it takes the current low digit of A and derives a quotient digit from the low digits of the accumulator, of B and of the precomputed constant m' = -M^(-1) mod r. It then adds a·B and q·M to the accumulator and shifts the sum right by one digit. The shift is exact, because the quotient digit clears the low digit of the sum.

A one-cycle start pulse, taken while the block is idle, captures A, B, M and m'. After exactly NUM_DIG iterations the block raises a one-cycle done pulse and holds the result until the next accepted start. The block never compares the result with M and never subtracts M at the end. The run time is therefore the same for every input. The result is only partially reduced: it stays below M + B, and it can be fed back in as an operand.

The block has two ways of use. In the first, NUM_DIG equals the digit count of M and 4M ≤ r^N; operands below 2M then give a result below 2M. In the second, NUM_DIG is one more than the digit count of M and the top digit of A is zero; operands below r^(N-1) then give a result below r^(N-1), unless the top digit of M is all ones.

Top module: `mont_mul_ds`

## Requirements
- R1: A start pulse sampled while busy_o is low captures a_i, b_i, m_i and mprime_i. While busy_o is high, start_i and the operand inputs have no effect on the result that is returned.
- R2: done_o is high for exactly one cycle. It rises NUM_DIG clock edges after the edge that sampled the accepted start, whatever the data.
- R3: In every iteration the quotient digit q = (p_0 + a_i·b_0)·m' mod r makes the sum P + a_i·B + q·M a multiple of r, and that sum fits in the accumulator without overflow.
- R4: When done_o is high, res_o·r^N ≡ A·B (mod M).
- R5: When done_o is high, A·B ≤ res_o·r^N < M·r^N + A·B. No final subtraction takes place.
- R6: During a run the accumulator stays below M + B, and the returned result is below M + B.
- R7: When 4M ≤ r^N and A, B < 2M, res_o < 2M.
- R8: When the top digit of A is zero, A, B < r^(N-1), M < r^(N-1) and the top digit of M (bits N·DIG_W-DIG_W-1 down to N·DIG_W-2·DIG_W) is not all ones, res_o < r^(N-1).
- R9: After reset, done_o and busy_o are low and res_o is zero.
- R10: res_o holds its value from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, accepted only while idle |
| a_i | input | NUM_DIG·DIG_W | Multiplier operand A, consumed low digit first |
| b_i | input | NUM_DIG·DIG_W | Multiplicand operand B |
| m_i | input | NUM_DIG·DIG_W | Odd modulus M |
| mprime_i | input | DIG_W | Digit constant -M^(-1) mod r |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| res_o | output | NUM_DIG·DIG_W+1 | Partially reduced Montgomery product |

## Verification
The assertions on exact division and on the bound P < M + B take for granted that the captured modulus is odd and that mprime_i really is the negated inverse of its low digit. With any other constant the low digit of the sum is not cleared and the invariant breaks. The stimulus uses only odd moduli, and for each one it finds m' by search over the r candidates. It keeps the operands below 2M in the stable mode and below r^(N-1) in the extended mode, so every run stays inside the range where the bounds are claimed.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mont_qdigit.sv
module mont_qdigit #(
  parameter int unsigned DIG_W = 4
) (
  input  logic [DIG_W-1:0] p0_i,
  input  logic [DIG_W-1:0] digit_i,
  input  logic [DIG_W-1:0] b0_i,
  input  logic [DIG_W-1:0] mprime_i,
  output logic [DIG_W-1:0] q_o
);

  generate
    if (DIG_W == 1) begin : g_bit
      // radix 2: m' is always 1, the product is a parity
      logic unused_mp;
      assign unused_mp = mprime_i[0];
      assign q_o       = p0_i ^ (digit_i & b0_i);
    end else begin : g_digit
      logic [DIG_W-1:0] ab_lo;
      logic [DIG_W-1:0] t_lo;
      // all arithmetic truncated to one digit: mod r for free
      assign ab_lo = digit_i * b0_i;
      assign t_lo  = p0_i + ab_lo;
      assign q_o   = t_lo * mprime_i;
    end
  endgenerate

endmodule

// File: rtl/mont_step.sv
module mont_step #(
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned OPW     = 12,
  localparam int unsigned RES_W  = OPW + 1,
  localparam int unsigned ACC_W  = OPW + DIG_W + 2
) (
  input  logic [RES_W-1:0] p_i,
  input  logic [DIG_W-1:0] digit_i,
  input  logic [DIG_W-1:0] q_i,
  input  logic [OPW-1:0]   b_i,
  input  logic [OPW-1:0]   m_i,
  output logic [ACC_W-1:0] sum_o
);

  logic [ACC_W-1:0] ab_t;
  logic [ACC_W-1:0] qm_t;

  generate
    if (DIG_W == 1) begin : g_gate
      assign ab_t = digit_i[0] ? ACC_W'(b_i) : '0;
      assign qm_t = q_i[0]     ? ACC_W'(m_i) : '0;
    end else begin : g_mul
      assign ab_t = ACC_W'(digit_i) * ACC_W'(b_i);
      assign qm_t = ACC_W'(q_i)     * ACC_W'(m_i);
    end
  endgenerate

  assign sum_o = ACC_W'(p_i) + ab_t + qm_t;

endmodule

// File: rtl/mont_seq.sv
module mont_seq
  import mont_pkg::*;
#(
  parameter int unsigned NUM_DIG = 3,
  localparam int unsigned CNT_W  = cnt_width(NUM_DIG)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(NUM_DIG - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (cnt_q == LAST_IT) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign cnt_en = start_i | (state_q == SEQ_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign load_o = (state_q == SEQ_IDLE) && start_i;
  assign step_o = (state_q == SEQ_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/mont_mul_ds.sv
module mont_mul_ds
  import mont_pkg::*;
#(
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned NUM_DIG = 3,
  localparam int unsigned OPW    = DIG_W * NUM_DIG,
  localparam int unsigned RES_W  = OPW + 1,
  localparam int unsigned ACC_W  = OPW + DIG_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  input  logic [OPW-1:0]   m_i,
  input  logic [DIG_W-1:0] mprime_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] res_o
);

  logic load, step;

  logic [OPW-1:0]   a_sh_q, a_sh_d;
  logic [OPW-1:0]   b_q, b_d;
  logic [OPW-1:0]   m_q, m_d;
  logic [DIG_W-1:0] mp_q, mp_d;
  logic [RES_W-1:0] p_q, p_d;
  logic             op_en, p_en;

  logic [DIG_W-1:0] digit;
  logic [DIG_W-1:0] qdig;
  logic [ACC_W-1:0] sum_w;
  logic [RES_W-1:0] p_nxt;

  mont_seq #(
    .NUM_DIG (NUM_DIG)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  assign digit = a_sh_q[DIG_W-1:0];

  mont_qdigit #(
    .DIG_W (DIG_W)
  ) u_qdig (
    .p0_i     (p_q[DIG_W-1:0]),
    .digit_i  (digit),
    .b0_i     (b_q[DIG_W-1:0]),
    .mprime_i (mp_q),
    .q_o      (qdig)
  );

  mont_step #(
    .DIG_W (DIG_W),
    .OPW   (OPW)
  ) u_step (
    .p_i     (p_q),
    .digit_i (digit),
    .q_i     (qdig),
    .b_i     (b_q),
    .m_i     (m_q),
    .sum_o   (sum_w)
  );

  // low digit is zero by choice of q: the divide by r is a shift
  assign p_nxt = sum_w[RES_W+DIG_W-1:DIG_W];

  always_comb begin
    a_sh_d = a_sh_q;
    b_d    = b_q;
    m_d    = m_q;
    mp_d   = mp_q;
    p_d    = p_q;
    if (load) begin
      a_sh_d = a_i;
      b_d    = b_i;
      m_d    = m_i;
      mp_d   = mprime_i;
      p_d    = '0;
    end else if (step) begin
      a_sh_d = a_sh_q >> DIG_W;
      p_d    = p_nxt;
    end
  end

  assign op_en = load;
  assign p_en  = load | step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q  <= '0;
      m_q  <= '0;
      mp_q <= '0;
    end else if (op_en) begin
      b_q  <= b_d;
      m_q  <= m_d;
      mp_q <= mp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_q <= '0;
      p_q    <= '0;
    end else if (p_en) begin
      a_sh_q <= a_sh_d;
      p_q    <= p_d;
    end
  end

  assign busy_o = step;
  assign res_o  = p_q;

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned NUM_DIG = 3,
  localparam int unsigned OPW    = DIG_W * NUM_DIG,
  localparam int unsigned RES_W  = OPW + 1,
  localparam int unsigned ACC_W  = OPW + DIG_W + 2,
  localparam int unsigned RC_W   = $clog2(NUM_DIG + 2) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic [RES_W-1:0] p_i,
  input logic [OPW-1:0]   b_i,
  input logic [OPW-1:0]   m_i,
  input logic [ACC_W-1:0] sum_i
);

  logic [RC_W-1:0]  run_cnt;
  logic [RES_W-1:0] lim;

  assign lim = RES_W'(m_i) + RES_W'(b_i);

  // counts edges since the accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
    end else if (start_i && !busy_i) begin
      run_cnt <= RC_W'(1);
    end else if (done_i) begin
      run_cnt <= '0;
    end else if (run_cnt != '0) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r1_ops_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(b_i) && $stable(m_i)));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (run_cnt == RC_W'(NUM_DIG + 1)));

  a_r3_exact_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (sum_i[DIG_W-1:0] == '0));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sum_i[ACC_W-1]);

  a_r6_invariant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || done_i) |-> (p_i < lim));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(p_i));

endmodule

bind mont_mul_ds mont_mul_chk #(
  .DIG_W   (DIG_W),
  .NUM_DIG (NUM_DIG)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .p_i     (p_q),
  .b_i     (b_q),
  .m_i     (m_q),
  .sum_i   (sum_w)
);

// File: tb/sim_mont_mul_ds.sv
`timescale 1ns/1ps
module sim_mont_mul_ds;

  localparam int W   = 4;
  localparam int N   = 3;
  localparam int OPW = W * N;
  localparam int RW  = OPW + 1;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [OPW-1:0] a_in, b_in, m_in;
  logic [W-1:0]   mp_in;
  logic           busy, done;
  logic [RW-1:0]  res;

  int checks   = 0;
  int failures = 0;

  mont_mul_ds #(.DIG_W(W), .NUM_DIG(N)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .a_i      (a_in),
    .b_i      (b_in),
    .m_i      (m_in),
    .mprime_i (mp_in),
    .busy_o   (busy),
    .done_o   (done),
    .res_o    (res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint find_mp(input longint m);
    longint r = longint'(1) << W;
    for (longint x = 0; x < r; x++)
      if (((m * x) + 1) % r == 0) return x;
    return 0;
  endfunction

  // mode 0: general, 1: stable (4M <= r^N), 2: extended iteration
  task automatic run(input longint a, input longint b, input longint m,
                     input bit disturb, input int mode);
    longint rn = longint'(1) << (W * N);
    longint p, pr, ab;
    int cyc;
    @(negedge clk);
    a_in  = OPW'(a);
    b_in  = OPW'(b);
    m_in  = OPW'(m);
    mp_in = W'(find_mp(m));
    start = 1'b1;
    @(negedge clk);
    cyc = 1;
    if (!disturb) start = 1'b0;
    // R1: inputs and start wiggle while busy
    else begin a_in = ~a_in; b_in = b_in ^ 12'h5a5; m_in = m_in + 12'd2; mp_in = ~mp_in; end
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (disturb && !done) begin
        a_in = a_in + 12'd37; b_in = b_in + 12'd91; m_in = m_in ^ 12'h0f0;
      end
    end
    start = 1'b0;
    chk(cyc == N + 1, "R2 latency", cyc, N + 1);
    p  = longint'(res);
    pr = p * rn;
    ab = a * b;
    chk((pr % m) == (ab % m), "R1 R3 R4 congruence", pr % m, ab % m);
    chk(pr >= ab && pr < m * rn + ab, "R5 bound", p, ab / rn);
    chk(p < m + b, "R6 below M+B", p, m + b);
    if (mode == 1) chk(p < 2 * m, "R7 stable below 2M", p, 2 * m);
    if (mode == 2) chk(p < (longint'(1) << (W * (N - 1))), "R8 extended fits",
                       p, longint'(1) << (W * (N - 1)));
    @(negedge clk);
    chk(!done, "R2 single cycle done", longint'(done), 0);
    chk(longint'(res) == p, "R10 result held", longint'(res), p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint stab_m[4] = '{257, 771, 1001, 1023};
    longint ext_m[4]  = '{17, 129, 201, 239};
    rst_n = 1'b0;
    start = 1'b0;
    a_in  = '0;
    b_in  = '0;
    m_in  = '0;
    mp_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done, "R9 done after reset", longint'(done), 0);
    chk(!busy, "R9 busy after reset", longint'(busy), 0);
    chk(res == '0, "R9 result after reset", longint'(res), 0);

    // exhaustive sweep, small modulus, all operands below 2M
    for (int a = 0; a < 26; a++)
      for (int b = 0; b < 26; b++)
        run(a, b, 13, (a * 26 + b) % 53 == 0, 1);

    // stable mode: 4M <= r^N, operands spread over [0, 2M)
    foreach (stab_m[k])
      for (int i = 0; i < 20; i++)
        for (int j = 0; j < 20; j++)
          run((longint'(i) * (2 * stab_m[k] - 1)) / 19,
              (longint'(j) * (2 * stab_m[k] - 1)) / 19,
              stab_m[k], (i + j) % 9 == 0, 1);

    // modulus with all-ones top digit, operands below M
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        run((longint'(i) * 4092) / 11, (longint'(j) * 4092) / 11, 4093, (i * j) % 7 == 3, 0);

    // extended iteration: M has N-1 digits, top digit of A zero
    foreach (ext_m[k])
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run(longint'(i) * 17, longint'(j) * 17, ext_m[k], (i + 2 * j) % 11 == 0, 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule